// File: doc/BRIEF.md
# Block-transfer wait/request handshake generator

This block produces the flow-control pins that let a serial channel move blocks of data without per-byte polling. Each channel owns one shared pin that serves either as a CPU wait line or as a DMA request line. A second pin can optionally serve as a transmit DMA request. Both pins are active low. In wait use, the shared pin is open-drain: it is released when idle and pulled low only while the CPU must stretch its access. In request use, it is always driven, and low means the channel can move a byte to or from memory.

Software selects a function with two mode bits and then turns it on with a separate enable bit. The selected mode only reaches the pin when the enable rises. Software can therefore choose the mode in one access and enable it in a later one without glitching the pin. All pins are registered. Each one reflects the inputs sampled at the previous clock edge. The channel count is a parameter, and the channels are fully independent.

Top module: `xfer_handshake`

## Requirements
- R1: While and directly after synchronous reset, every shared pin is released (`wreq_oe`=0, `wreq_n`=1) and every transmit request pin is inactive (`txdrq_n`=1). The applied mode is wait-on-transmit, disabled.
- R2: When a channel's applied enable is low, its shared pin is released, whatever the buffer flags or strobes are.
- R3: A channel's 2-bit mode field (bit 1: 0 = wait, 1 = request; bit 0: 0 = transmit, 1 = receive) is captured only on the clock where its enable is sampled high after being low. Mode changes made while enabled have no effect until the enable is dropped and raised again.
- R4: In wait-on-transmit (mode 00), a write strobe sampled while the transmit buffer is full drives the shared pin low on the next cycle. It stays low until the cycle after the full flag is sampled low.
- R5: In wait-on-receive (mode 01), a read strobe sampled while no received character is available drives the shared pin low. It stays low until the cycle after a character is sampled available.
- R6: In wait modes the shared pin is never driven high: it is either released (`wreq_oe`=0, `wreq_n`=1) or driven low (`wreq_oe`=1, `wreq_n`=0). A write to a non-full buffer or a read with a character available leaves it released.
- R7: In request-on-transmit (mode 10), `wreq_n` is low in each cycle after an edge that sampled the buffer not full and no write strobe. A write strobe makes it high on the next cycle.
- R8: In request-on-receive (mode 11), `wreq_n` is low in each cycle after an edge that sampled a character available and no read strobe. A read strobe makes it high on the next cycle.
- R9: In request modes, the shared pin is always driven (`wreq_oe`=1), both when asserted and when deasserted.
- R10: When a channel's transmit-request configuration bit is set, its `txdrq_n` follows the R7 rule (low when not full and no write). One cycle after the bit is sampled clear, `txdrq_n` stays high.
- R11: Channels are independent. Configuration and flags of one channel never change another channel's pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| func_en | input | NCH | Per-channel function enable |
| mode_sel | input | 2*NCH | Per-channel mode field, channel c at bits [2c+1:2c] |
| txreq_en | input | NCH | Per-channel transmit-request pin configuration |
| tx_full | input | NCH | Transmit buffer full flag |
| rx_avail | input | NCH | Received character available flag |
| cpu_wr | input | NCH | CPU write strobe to the transmit buffer |
| cpu_rd | input | NCH | CPU read strobe from the receive buffer |
| wreq_n | output | NCH | Shared wait/request pin level, active low |
| wreq_oe | output | NCH | Drive enable of the shared pin (0 = released) |
| txdrq_n | output | NCH | Transmit request pin, active low |

## Verification
The hardest case to reach is a mode change while a channel is already enabled, because that change must leave no trace on the pin. The stimulus enables wait-on-receive and then rewrites the mode field to request-on-transmit with an empty transmit buffer, a state that would drive the pin at once if the change were taken. The bench then shows the pin still released for several cycles, and still answering a blocked read as a wait. The next case is a full drop-and-raise of the enable, after which the new request mode appears. Wait holding is driven by keeping the full or empty flag pinned across several cycles after a single strobe.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int MODE_W  = 2;
  localparam int REQ_BIT = 1;   // 1 = request use, 0 = wait use
  localparam int DIR_BIT = 0;   // 1 = receive side, 0 = transmit side
  localparam int NDIR    = 2;   // transmit and receive

  typedef enum logic [MODE_W-1:0] {
    XM_WAIT_TX = 2'b00,
    XM_WAIT_RX = 2'b01,
    XM_REQ_TX  = 2'b10,
    XM_REQ_RX  = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/hs_cfg_gate.sv
module hs_cfg_gate
  import hs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              func_en,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              txreq_in,
  output logic              en_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              txcfg_q
);
  logic capture;
  assign capture = func_en && !en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      mode_q  <= XM_WAIT_TX;
      txcfg_q <= 1'b0;
    end else begin
      en_q    <= func_en;
      txcfg_q <= txreq_in;
      if (capture) mode_q <= mode_in;
    end
  end

  // R3: the applied mode never moves while the enable stays up
  assert_mode_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    (en_q && $past(en_q)) |-> $stable(mode_q));
endmodule

// File: rtl/hs_wait_unit.sv
module hs_wait_unit (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic strobe,
  input  logic blocked,
  output logic wait_nx
);
  logic wait_q;
  assign wait_nx = arm && blocked && (strobe || wait_q);

  always_ff @(posedge clk) begin
    if (rst) wait_q <= 1'b0;
    else     wait_q <= wait_nx;
  end

  // R4 (transmit instance) and R5 (receive instance): a wait only starts from a blocked access
  assert_wait_cause_R4: assert property (@(posedge clk) disable iff (rst)
    (wait_q && !$past(wait_q)) |-> $past(strobe && blocked));

  // R5: a wait never survives a cycle in which the access was unblocked
  assert_wait_release_R5: assert property (@(posedge clk) disable iff (rst)
    $past(!blocked) |-> !wait_q);
endmodule

// File: rtl/hs_req_unit.sv
module hs_req_unit (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic ready,
  input  logic strobe,
  output logic req_nx
);
  logic req_q;
  assign req_nx = arm && ready && !strobe;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= req_nx;
  end

  // R7: the transfer strobe withdraws the request on the next cycle
  assert_req_strobe_drop_R7: assert property (@(posedge clk) disable iff (rst)
    $past(strobe) |-> !req_q);

  // R8: a request needs an armed unit with data or space ready
  assert_req_needs_ready_R8: assert property (@(posedge clk) disable iff (rst)
    req_q |-> $past(arm && ready));
endmodule

// File: rtl/hs_chan.sv
module hs_chan
  import hs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              func_en,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              txreq_en,
  input  logic              tx_full,
  input  logic              rx_avail,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic              wreq_n,
  output logic              wreq_oe,
  output logic              txdrq_n
);
  logic              en_q;
  logic              txcfg_q;
  logic [MODE_W-1:0] mode_q;

  hs_cfg_gate u_cfg (
    .clk      (clk),
    .rst      (rst),
    .func_en  (func_en),
    .mode_in  (mode_sel),
    .txreq_in (txreq_en),
    .en_q     (en_q),
    .mode_q   (mode_q),
    .txcfg_q  (txcfg_q)
  );

  logic [NDIR-1:0] blocked, ready, strobe, arm_w, arm_r, wait_nx, req_nx;
  assign blocked = {~rx_avail, tx_full};
  assign ready   = {rx_avail, ~tx_full};
  assign strobe  = {cpu_rd, cpu_wr};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    assign arm_w[d] = en_q && !mode_q[REQ_BIT] && (mode_q[DIR_BIT] == 1'(d));
    assign arm_r[d] = en_q &&  mode_q[REQ_BIT] && (mode_q[DIR_BIT] == 1'(d));

    hs_wait_unit u_wait (
      .clk     (clk),
      .rst     (rst),
      .arm     (arm_w[d]),
      .strobe  (strobe[d]),
      .blocked (blocked[d]),
      .wait_nx (wait_nx[d])
    );

    hs_req_unit u_req (
      .clk    (clk),
      .rst    (rst),
      .arm    (arm_r[d]),
      .ready  (ready[d]),
      .strobe (strobe[d]),
      .req_nx (req_nx[d])
    );
  end

  logic tx_nx;
  hs_req_unit u_txreq (
    .clk    (clk),
    .rst    (rst),
    .arm    (txcfg_q),
    .ready  (~tx_full),
    .strobe (cpu_wr),
    .req_nx (tx_nx)
  );

  logic req_use;
  assign req_use = en_q && mode_q[REQ_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      wreq_n  <= 1'b1;
      wreq_oe <= 1'b0;
      txdrq_n <= 1'b1;
    end else begin
      wreq_oe <= req_use || (|wait_nx);
      wreq_n  <= !((|wait_nx) || (|req_nx));
      txdrq_n <= !tx_nx;
    end
  end

  // R6: in wait use the pin is either released or pulled low, never driven high
  assert_wait_opendrain_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(req_use) |-> (wreq_oe == !wreq_n));

  // R9: request use keeps the pin driven in both levels
  assert_req_driven_R9: assert property (@(posedge clk) disable iff (rst)
    $past(req_use) |-> wreq_oe);

  // R2: a disabled channel releases the shared pin
  assert_idle_release_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!en_q) |-> (!wreq_oe && wreq_n));

  // R10: a cleared transmit-request configuration keeps its pin high
  assert_txreq_off_R10: assert property (@(posedge clk) disable iff (rst)
    $past(!txcfg_q) |-> txdrq_n);
endmodule

// File: rtl/xfer_handshake.sv
module xfer_handshake
  import hs_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        func_en,
  input  logic [MODE_W*NCH-1:0] mode_sel,
  input  logic [NCH-1:0]        txreq_en,
  input  logic [NCH-1:0]        tx_full,
  input  logic [NCH-1:0]        rx_avail,
  input  logic [NCH-1:0]        cpu_wr,
  input  logic [NCH-1:0]        cpu_rd,
  output logic [NCH-1:0]        wreq_n,
  output logic [NCH-1:0]        wreq_oe,
  output logic [NCH-1:0]        txdrq_n
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    hs_chan u_chan (
      .clk      (clk),
      .rst      (rst),
      .func_en  (func_en[c]),
      .mode_sel (mode_sel[MODE_W*c +: MODE_W]),
      .txreq_en (txreq_en[c]),
      .tx_full  (tx_full[c]),
      .rx_avail (rx_avail[c]),
      .cpu_wr   (cpu_wr[c]),
      .cpu_rd   (cpu_rd[c]),
      .wreq_n   (wreq_n[c]),
      .wreq_oe  (wreq_oe[c]),
      .txdrq_n  (txdrq_n[c])
    );
  end

  // R1: reset leaves every pin released and inactive
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> ((wreq_oe == '0) && (wreq_n == '1) && (txdrq_n == '1)));
endmodule

// File: tb/sim_xfer_handshake.sv
module sim_xfer_handshake;
  localparam int NCH = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst;
  logic [NCH-1:0]   func_en, txreq_en, tx_full, rx_avail, cpu_wr, cpu_rd;
  logic [2*NCH-1:0] mode_sel;
  logic [NCH-1:0]   wreq_n, wreq_oe, txdrq_n;

  xfer_handshake #(.NCH(NCH)) u0 (
    .clk(clk), .rst(rst), .func_en(func_en), .mode_sel(mode_sel),
    .txreq_en(txreq_en), .tx_full(tx_full), .rx_avail(rx_avail),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .wreq_n(wreq_n), .wreq_oe(wreq_oe), .txdrq_n(txdrq_n)
  );

  typedef struct {
    int             req;
    bit             chk;
    logic [NCH-1:0] wn, oe, tn;
  } item_t;

  item_t q[$];
  int  checks = 0;
  int  failures = 0;
  bit  finished = 0;

  // driver side: push the expectation for the outputs after the next edge
  task automatic step(input int req, input bit chk,
                      input logic [NCH-1:0] wn, input logic [NCH-1:0] oe,
                      input logic [NCH-1:0] tn);
    item_t it;
    it.req = req; it.chk = chk; it.wn = wn; it.oe = oe; it.tn = tn;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic skip();
    step(0, 1'b0, '1, '0, '1);
  endtask

  // monitor side: pop one expectation per edge and compare
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        if (it.chk) begin
          checks++;
          if (wreq_n !== it.wn || wreq_oe !== it.oe || txdrq_n !== it.tn) begin
            failures++;
            $display("FAIL R%0d wreq_n=%b wreq_oe=%b txdrq_n=%b expected %b %b %b",
                     it.req, wreq_n, wreq_oe, txdrq_n, it.wn, it.oe, it.tn);
          end
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; func_en = '0; txreq_en = '0; tx_full = '0; rx_avail = '0;
    cpu_wr = '0; cpu_rd = '0; mode_sel = '0;
    @(negedge clk);
    skip(); skip();
    step(1, 1, 2'b11, 2'b00, 2'b11);               // R1 during reset
    rst = 0;
    step(1, 1, 2'b11, 2'b00, 2'b11);               // R1 after reset

    // wait-on-transmit on channel 0 (mode 00)
    mode_sel[1:0] = 2'b00; func_en[0] = 1; skip();
    step(6, 1, 2'b11, 2'b00, 2'b11);               // R6 idle: released
    tx_full[0] = 1; cpu_wr[0] = 1;
    step(4, 1, 2'b10, 2'b01, 2'b11);               // R4 blocked write
    cpu_wr[0] = 0;
    step(4, 1, 2'b10, 2'b01, 2'b11);               // R4 held
    step(4, 1, 2'b10, 2'b01, 2'b11);
    tx_full[0] = 0;
    step(4, 1, 2'b11, 2'b00, 2'b11);               // R4 released
    cpu_wr[0] = 1;
    step(6, 1, 2'b11, 2'b00, 2'b11);               // R6 unblocked write
    cpu_wr[0] = 0;

    // wait-on-receive (mode 01)
    func_en[0] = 0; skip();
    mode_sel[1:0] = 2'b01; func_en[0] = 1; skip();
    rx_avail[0] = 0; cpu_rd[0] = 1;
    step(5, 1, 2'b10, 2'b01, 2'b11);               // R5 blocked read
    cpu_rd[0] = 0;
    step(5, 1, 2'b10, 2'b01, 2'b11);
    rx_avail[0] = 1;
    step(5, 1, 2'b11, 2'b00, 2'b11);               // R5 released
    cpu_rd[0] = 1;
    step(5, 1, 2'b11, 2'b00, 2'b11);               // R5 read with data
    cpu_rd[0] = 0;

    // R3: mode rewrite while enabled is ignored
    mode_sel[1:0] = 2'b10; tx_full[0] = 0; skip();
    step(3, 1, 2'b11, 2'b00, 2'b11);
    step(3, 1, 2'b11, 2'b00, 2'b11);
    rx_avail[0] = 0; cpu_rd[0] = 1;
    step(3, 1, 2'b10, 2'b01, 2'b11);               // R3 still wait-on-receive
    cpu_rd[0] = 0; rx_avail[0] = 1;
    step(3, 1, 2'b11, 2'b00, 2'b11);

    // request-on-transmit (mode 10 captured on re-enable)
    func_en[0] = 0; skip();
    func_en[0] = 1; skip();
    step(7, 1, 2'b10, 2'b01, 2'b11);               // R7 empty buffer requests
    cpu_wr[0] = 1;
    step(9, 1, 2'b11, 2'b01, 2'b11);               // R9 deasserted yet driven
    cpu_wr[0] = 0; tx_full[0] = 1;
    step(7, 1, 2'b11, 2'b01, 2'b11);
    tx_full[0] = 0;
    step(7, 1, 2'b10, 2'b01, 2'b11);

    // R2: disabling releases the pin
    func_en[0] = 0; skip();
    step(2, 1, 2'b11, 2'b00, 2'b11);
    tx_full[0] = 1; cpu_wr[0] = 1;
    step(2, 1, 2'b11, 2'b00, 2'b11);               // R2 blocked write ignored
    cpu_wr[0] = 0; tx_full[0] = 0;

    // request-on-receive (mode 11)
    mode_sel[1:0] = 2'b11; func_en[0] = 1; skip();
    step(8, 1, 2'b10, 2'b01, 2'b11);               // R8 character available
    cpu_rd[0] = 1;
    step(8, 1, 2'b11, 2'b01, 2'b11);
    cpu_rd[0] = 0; rx_avail[0] = 0;
    step(8, 1, 2'b11, 2'b01, 2'b11);
    rx_avail[0] = 1;
    step(8, 1, 2'b10, 2'b01, 2'b11);

    // R10: transmit request pin
    txreq_en[0] = 1; skip();
    step(10, 1, 2'b10, 2'b01, 2'b10);
    cpu_wr[0] = 1;
    step(10, 1, 2'b10, 2'b01, 2'b11);
    cpu_wr[0] = 0; tx_full[0] = 1;
    step(10, 1, 2'b10, 2'b01, 2'b11);
    tx_full[0] = 0;
    step(10, 1, 2'b10, 2'b01, 2'b10);
    txreq_en[0] = 0; skip();
    step(10, 1, 2'b10, 2'b01, 2'b11);

    // R11: channel 1 alone in request-on-transmit
    func_en[0] = 0;
    mode_sel[3:2] = 2'b10; func_en[1] = 1; tx_full[1] = 0; skip();
    step(11, 1, 2'b01, 2'b10, 2'b11);
    tx_full[1] = 1; tx_full[0] = 1; cpu_wr[0] = 1;
    step(11, 1, 2'b11, 2'b10, 2'b11);
    cpu_wr[0] = 0;
    step(11, 1, 2'b11, 2'b10, 2'b11);

    skip(); skip();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule